// File: doc/BRIEF.md
# DMA Completion Interrupt and CPU Holdoff Controller

This block handles the interrupt side of a small multi-channel DMA engine. Each channel has a programmable transfer size. A start pulse loads that size into a down-counter. Each transfer step then decrements the counter. When the counter reaches zero, the channel's completion flag is set. The flags are sticky and only a software clear resets them.

Each flag is qualified by its own channel enable and by the CPU's global interrupt enable. The qualified flags are merged with a request from a neighbouring converter peripheral onto one shared interrupt line. A status port returns every channel flag together with the neighbour's flag, so a service routine can find out which source raised the shared line.

While any channel is transferring, the block holds the CPU off, so maskable system interrupts stay pending until the transfer ends. A pending non-maskable interrupt gets a one-cycle gap in the holdoff, but only if the NMI-admit enable is set. Address generation and data movement belong to the surrounding engine.

Top module: `dma_irq_ctrl`

## Requirements
- R1: `src_status[i]` (for i below NCH) is channel i's completion flag, and `src_status[NCH]` mirrors `peer_req`. A busy channel whose counter is at 1 sets its flag at the clock edge where it takes a step. That step also makes the channel idle.
- R2: A start on a channel whose size register holds 0 sets that channel's flag at the same edge and leaves the channel idle, so `cpu_hold` does not rise.
- R3: `irq` equals `peer_req` OR (`gie` AND the OR over channels of flag AND enable bit), combinationally from the registered flags and enables.
- R4: Flags are sticky. A `flag_clr[i]` pulse resets flag i. If a set and a clear of the same flag fall in one cycle, the flag ends up set.
- R5: `cpu_hold` is high in every cycle where at least one channel is busy and no NMI gap is open. A channel is busy from the edge after its start until the edge of its final step.
- R6: When `nmi_pend` is high at an edge while a channel is busy, `nmi_admit_q` is 1 and no gap was open, `cpu_hold` drops for exactly the next cycle. Two gaps are never adjacent. With `nmi_admit_q` at 0, no gap ever opens.
- R7: A step on an idle channel has no effect. A start on a busy channel reloads its counter from the size register. When start and step coincide, start wins.
- R8: Reset clears all flags, enables, size registers, counters and the holdoff.
- R9: `ctl_wr` loads `ctl_ie` (bit i enables channel i) and `ctl_nmi_admit`. `size_wr[i]` loads `size_wdata` into channel i's size register. A start uses the value the register held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_start | input | NCH | Per-channel transfer start pulse |
| ch_step | input | NCH | Per-channel transfer step pulse |
| size_wr | input | NCH | Per-channel size register write strobe |
| size_wdata | input | CW | Size write data |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_ie | input | NCH | Channel interrupt enables (write data) |
| ctl_nmi_admit | input | 1 | NMI-admit enable (write data) |
| flag_clr | input | NCH | Per-channel flag clear pulse |
| gie | input | 1 | CPU global interrupt enable |
| peer_req | input | 1 | Neighbouring peripheral interrupt flag |
| nmi_pend | input | 1 | Non-maskable interrupt pending |
| irq | output | 1 | Shared interrupt request |
| cpu_hold | output | 1 | CPU holdoff while transferring |
| src_status | output | NCH+1 | Flags read port: {peer flag, channel flags} |

## Verification
Every register takes one edge. A start or final step is reflected in `cpu_hold` and `src_status` in the cycle after that edge. A control write takes effect one edge later, and an NMI gap opens one edge after `nmi_pend` is seen. That puts the gap two edges after a write that enables admission. `irq` follows `gie` and `peer_req` within the same cycle.

The bench drives inputs one time unit after the rising edge. It compares all outputs against a behavioural model at the falling edge, and makes its named scenario checks after the edge that the requirement's latency points to.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  typedef enum logic {CH_IDLE = 1'b0, CH_BUSY = 1'b1} ch_state_e;
endpackage

// File: rtl/dma_ch_tracker.sv
module dma_ch_tracker
  import dma_irq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          step,
  input  logic          size_wr,
  input  logic [CW-1:0] size_wdata,
  input  logic          clr,
  output logic          busy,
  output logic          flag
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] ZERO = '0;

  ch_state_e     state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] size_q, size_d;
  logic          flag_q, flag_d;
  logic          done_set;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    done_set = 1'b0;
    size_d   = size_wr ? size_wdata : size_q;
    if (start) begin
      if (size_q == ZERO) begin
        state_d  = CH_IDLE;
        cnt_d    = ZERO;
        done_set = 1'b1;
      end else begin
        state_d = CH_BUSY;
        cnt_d   = size_q;
      end
    end else if (state_q == CH_BUSY && step) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) begin
        state_d  = CH_IDLE;
        done_set = 1'b1;
      end
    end
    flag_d = done_set | (flag_q & ~clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= ZERO;
      size_q  <= ZERO;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      size_q  <= size_d;
      flag_q  <= flag_d;
    end
  end

  assign busy = (state_q == CH_BUSY);
  assign flag = flag_q;

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);
  assert_last_step_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !start && cnt_q == ONE) |=> (flag_q && !busy));
  assert_idle_step_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(cnt_q) && !busy));
  assert_zero_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && size_q == ZERO) |=> (flag_q && !busy));
endmodule

// File: rtl/dma_holdoff.sv
module dma_holdoff #(
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] busy,
  input  logic           nmi_admit,
  input  logic           nmi_pend,
  output logic           hold
);
  logic any_busy;
  logic gap_q, gap_d;

  assign any_busy = |busy;

  always_comb begin
    gap_d = nmi_pend & nmi_admit & any_busy & ~gap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_q <= 1'b0;
    else        gap_q <= gap_d;
  end

  assign hold = any_busy & ~gap_q;

  assert_gap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q |=> !gap_q);
  assert_gap_needs_admit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !nmi_admit |=> !gap_q);
  assert_hold_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> any_busy);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl #(
  parameter int NCH = 3,
  parameter int CW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_start,
  input  logic [NCH-1:0] ch_step,
  input  logic [NCH-1:0] size_wr,
  input  logic [CW-1:0]  size_wdata,
  input  logic           ctl_wr,
  input  logic [NCH-1:0] ctl_ie,
  input  logic           ctl_nmi_admit,
  input  logic [NCH-1:0] flag_clr,
  input  logic           gie,
  input  logic           peer_req,
  input  logic           nmi_pend,
  output logic           irq,
  output logic           cpu_hold,
  output logic [NCH:0]   src_status
);
  localparam int SW = NCH + 1;

  logic [NCH-1:0] ie_q, ie_d;
  logic           nmi_admit_q, nmi_admit_d;
  logic [NCH-1:0] busy;
  logic [NCH-1:0] flags;

  always_comb begin
    ie_d        = ctl_wr ? ctl_ie : ie_q;
    nmi_admit_d = ctl_wr ? ctl_nmi_admit : nmi_admit_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q        <= '0;
      nmi_admit_q <= 1'b0;
    end else begin
      ie_q        <= ie_d;
      nmi_admit_q <= nmi_admit_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_ch_tracker #(.CW(CW)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (ch_start[g]),
      .step       (ch_step[g]),
      .size_wr    (size_wr[g]),
      .size_wdata (size_wdata),
      .clr        (flag_clr[g]),
      .busy       (busy[g]),
      .flag       (flags[g])
    );
  end

  dma_holdoff #(.NCH(NCH)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .nmi_admit (nmi_admit_q),
    .nmi_pend  (nmi_pend),
    .hold      (cpu_hold)
  );

  assign irq        = peer_req | (gie & |(flags & ie_q));
  assign src_status = SW'({peer_req, flags});

  assert_peer_reaches_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    peer_req |-> irq);
  assert_gie_blocks_dma_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gie && !peer_req) |-> !irq);
  assert_status_peer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    src_status[NCH] == peer_req);
endmodule

// File: tb/tb_dma_irq_ctrl.sv
module tb_dma_irq_ctrl;
  localparam int NCH = 3;
  localparam int CW  = 16;
  localparam time TCLK = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] ch_start = '0, ch_step = '0, size_wr = '0, ctl_ie = '0, flag_clr = '0;
  logic [CW-1:0]  size_wdata = '0;
  logic ctl_wr = 1'b0, ctl_nmi_admit = 1'b0, gie = 1'b0, peer_req = 1'b0, nmi_pend = 1'b0;
  logic irq, cpu_hold;
  logic [NCH:0] src_status;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  dma_irq_ctrl #(.NCH(NCH), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .ch_start(ch_start), .ch_step(ch_step),
    .size_wr(size_wr), .size_wdata(size_wdata), .ctl_wr(ctl_wr), .ctl_ie(ctl_ie),
    .ctl_nmi_admit(ctl_nmi_admit), .flag_clr(flag_clr), .gie(gie),
    .peer_req(peer_req), .nmi_pend(nmi_pend), .irq(irq), .cpu_hold(cpu_hold),
    .src_status(src_status)
  );

  // behavioural reference model
  int m_sz[NCH], m_cnt[NCH];
  bit m_act[NCH], m_flg[NCH], m_ie[NCH];
  bit m_nen, m_gap;

  function automatic bit m_any();
    bit a = 0;
    for (int i = 0; i < NCH; i++) a |= m_act[i];
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        m_sz[i] <= 0; m_cnt[i] <= 0; m_act[i] <= 0; m_flg[i] <= 0; m_ie[i] <= 0;
      end
      m_nen <= 0; m_gap <= 0;
    end else begin
      m_gap <= nmi_pend && m_nen && m_any() && !m_gap;
      if (ctl_wr) m_nen <= ctl_nmi_admit;
      for (int i = 0; i < NCH; i++) begin
        bit setf;
        setf = 0;
        if (ctl_wr) m_ie[i] <= ctl_ie[i];
        if (size_wr[i]) m_sz[i] <= int'(size_wdata);
        if (ch_start[i]) begin
          if (m_sz[i] == 0) begin setf = 1; m_act[i] <= 0; m_cnt[i] <= 0; end
          else begin m_act[i] <= 1; m_cnt[i] <= m_sz[i]; end
        end else if (m_act[i] && ch_step[i]) begin
          m_cnt[i] <= m_cnt[i] - 1;
          if (m_cnt[i] == 1) begin m_act[i] <= 0; setf = 1; end
        end
        m_flg[i] <= setf ? 1'b1 : (flag_clr[i] ? 1'b0 : m_flg[i]);
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NCH:0] es;
      bit ei;
      ei = 0;
      for (int i = 0; i < NCH; i++) begin
        es[i] = m_flg[i];
        ei |= m_flg[i] & m_ie[i];
      end
      es[NCH] = peer_req;
      chk("R3 irq", 32'(irq), 32'(peer_req | (gie & ei)));
      chk("R5/R6 cpu_hold", 32'(cpu_hold), 32'(m_any() && !m_gap));
      chk("R1/R2/R4/R7 src_status", 32'(src_status), 32'(es));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
    ch_start = '0; ch_step = '0; size_wr = '0; ctl_wr = 1'b0; flag_clr = '0;
  endtask

  task automatic wr_size(int ch, int val);
    size_wr[ch] = 1'b1; size_wdata = CW'(val); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3;
    chk("R8 reset irq", 32'(irq), 0);
    chk("R8 reset hold", 32'(cpu_hold), 0);
    chk("R8 reset status", 32'(src_status), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    tick();
    gie = 1'b1;
    // R9 control and size writes
    ctl_wr = 1'b1; ctl_ie = '1; ctl_nmi_admit = 1'b0; tick();
    wr_size(0, 3);
    ch_start[0] = 1'b1; tick();
    chk("R5 hold after start", 32'(cpu_hold), 1);
    ch_step[0] = 1'b1; tick(); tick();
    ch_step[0] = 1'b1; tick();
    chk("R1 flag not early", 32'(src_status[0]), 0);
    ch_step[0] = 1'b1; tick();
    chk("R1 flag after last step", 32'(src_status[0]), 1);
    chk("R5 hold off after last step", 32'(cpu_hold), 0);
    chk("R3 irq enabled", 32'(irq), 1);
    gie = 1'b0; #1;
    chk("R3 gie masks", 32'(irq), 0);
    gie = 1'b1;
    tick(); tick();
    chk("R4 flag sticky", 32'(src_status[0]), 1);
    flag_clr[0] = 1'b1; tick();
    chk("R4 flag cleared", 32'(src_status[0]), 0);
    // R2 zero-size start on channel 2
    ch_start[2] = 1'b1; tick();
    chk("R2 zero start flag", 32'(src_status[2]), 1);
    chk("R2 zero start no hold", 32'(cpu_hold), 0);
    flag_clr[2] = 1'b1; tick();
    // R4 set beats clear
    wr_size(1, 1);
    ch_start[1] = 1'b1; tick();
    ch_step[1] = 1'b1; flag_clr[1] = 1'b1; tick();
    chk("R4 set wins over clear", 32'(src_status[1]), 1);
    flag_clr[1] = 1'b1; tick();
    // R6 NMI admission
    wr_size(0, 5);
    ch_start[0] = 1'b1; tick();
    nmi_pend = 1'b1; tick(); tick();
    chk("R6 no gap while disabled", 32'(cpu_hold), 1);
    ctl_wr = 1'b1; ctl_ie = '1; ctl_nmi_admit = 1'b1; tick();
    chk("R6 gap not yet", 32'(cpu_hold), 1);
    tick();
    chk("R6 gap opens", 32'(cpu_hold), 0);
    tick();
    chk("R6 gap lasts one cycle", 32'(cpu_hold), 1);
    nmi_pend = 1'b0; tick();
    // R7 restart with coincident step reloads 5
    ch_step[0] = 1'b1; tick();
    ch_start[0] = 1'b1; ch_step[0] = 1'b1; tick();
    for (int k = 0; k < 4; k++) begin ch_step[0] = 1'b1; tick(); end
    chk("R7 reload after restart", 32'(src_status[0]), 0);
    chk("R7 still busy", 32'(cpu_hold), 1);
    ch_step[0] = 1'b1; tick();
    chk("R7 done after reload", 32'(src_status[0]), 1);
    flag_clr[0] = 1'b1; tick();
    ch_step = '1; tick();
    chk("R7 idle step ignored status", 32'(src_status), 0);
    chk("R7 idle step ignored hold", 32'(cpu_hold), 0);
    // R3 peer request on shared line
    gie = 1'b0; peer_req = 1'b1; #1;
    chk("R3 peer raises irq", 32'(irq), 1);
    chk("R1 peer in status", 32'(src_status[NCH]), 1);
    peer_req = 1'b0; gie = 1'b1; tick();
    // R8 reset mid-transfer
    ch_start[0] = 1'b1; tick();
    rst_n = 1'b0; #1;
    chk("R8 reset drops hold", 32'(cpu_hold), 0);
    chk("R8 reset clears status", 32'(src_status), 0);
    tick(); rst_n = 1'b1; tick();
    // randomized traffic, model compared every cycle
    ctl_wr = 1'b1; ctl_ie = 3'b101; ctl_nmi_admit = 1'b1; tick();
    for (int n = 0; n < 600; n++) begin
      size_wdata = CW'($urandom_range(0, 4));
      size_wr    = NCH'($urandom_range(0, 7) & (($urandom_range(0, 3) == 0) ? 7 : 0));
      ch_start   = NCH'(($urandom_range(0, 7) == 0) ? $urandom_range(1, 7) : 0);
      ch_step    = NCH'($urandom_range(0, 7));
      flag_clr   = NCH'(($urandom_range(0, 5) == 0) ? $urandom_range(0, 7) : 0);
      ctl_wr     = ($urandom_range(0, 30) == 0);
      ctl_ie     = NCH'($urandom_range(0, 7));
      ctl_nmi_admit = $urandom_range(0, 1);
      gie        = $urandom_range(0, 3) != 0;
      peer_req   = $urandom_range(0, 9) == 0;
      nmi_pend   = $urandom_range(0, 2) == 0;
      @(posedge clk); #1;
    end
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule